// File: doc/BRIEF.md
# Transmit Abort Recovery Controller

This block owns the transmit FIFO pointers and the host data-request line of a MAC transmit path. When the transmit engine gives up on a frame (late collision, carrier loss, too many retries), it pulses an abort input. The block then holds off all further transmission and drops the data request. It does nothing to the pointers until the host reads the transmit status.

When that status read comes, the recovery depends on how much of the aborted frame reached the FIFO. If the host already wrote the frame's end-of-frame byte, the read pointer jumps past the frame to where the next frame begins, and the write pointer is left alone. If no end-of-frame marker was written, the whole transmit path is cleared, and the working watermark is reloaded from the configuration input.

To know where the next frame begins, the block keeps a small queue. It records the address that follows each end-of-frame byte. A frame counter counts complete frames whose status has not yet been read. It can be read freely, and only a status read lowers it.

Top module: `tx_abort_recovery`

## Requirements
- R1: After reset, both pointers and the frame count are zero, `tx_hold` is low, and `data_req` is high (16 free entries against the reset watermark of 8).
- R2: A write advances `wr_ptr` by one unless the FIFO holds 16 entries. A read advances `rd_ptr` by one when the FIFO is not empty and `tx_hold` is low. Both pointers are 5 bits wide and wrap modulo 32.
- R3: A write with `wr_eof` set raises `frame_cnt` by one and records the address that follows that byte. While 4 such addresses are held, a write with `wr_eof` set is ignored entirely.
- R4: An abort sets `tx_hold` in the next cycle. While `tx_hold` is high, reads are ignored and `data_req` stays low; only a status read clears `tx_hold`.
- R5: A status read with an abort pending, and at least one recorded frame end, sets `rd_ptr` to the oldest recorded address. That entry is dropped, and `wr_ptr` is unchanged.
- R6: A status read with an abort pending and no recorded frame end sets both pointers and `frame_cnt` to zero, empties the queue, and loads the working watermark from `cfg_wmark`. A write in that same cycle is dropped.
- R7: Each status read lowers `frame_cnt` by one, stopping at zero. Nothing else lowers it apart from the clear in R6.
- R8: A status read with no abort pending leaves both pointers unchanged.
- R9: `data_req` is a register. It is high exactly when `tx_hold` is low and the free space (16 minus occupancy) is at or above the working watermark. It rises in the cycle after the releasing status read. Changes on `cfg_wmark` have no effect until the next clear under R6.
- R10: An abort that arrives while `tx_hold` is already high has no effect, so a single status read still releases the hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host writes one byte into the transmit FIFO |
| wr_eof | input | 1 | The byte written this cycle ends a frame |
| rd_en | input | 1 | Transmit engine takes one byte from the FIFO |
| abort | input | 1 | Transmit engine abandoned the current frame |
| stat_rd | input | 1 | Host reads the transmit status |
| cfg_wmark | input | 5 | Configured free-space watermark |
| wr_ptr | output | 5 | FIFO write pointer |
| rd_ptr | output | 5 | FIFO read pointer |
| frame_cnt | output | 4 | Complete frames whose status is unread |
| tx_hold | output | 1 | Transmission suspended after an abort |
| data_req | output | 1 | Host data request |

## Verification
The bench aims at the fork taken at the status read. An abort with a completed frame must skip the read pointer to that frame's recorded end. A design that chose the wrong branch would either wipe frames that were already queued, or leave a half-written frame to be sent. It also covers:
- a second abort during the hold, where a design that counts aborts would never release;
- a read attempted during the hold, which a leaky design would let move `rd_ptr`;
- watermark edits between clears, which a design that skips the working copy would act on at once;
- the full FIFO and the full boundary queue, where a design would overwrite data or lose track of frame ends.

// File: rtl/txr_pkg.sv
package txr_pkg;

    // Recovery action chosen when the host reads the transmit status
    typedef enum logic [1:0] {
        ACT_NONE  = 2'd0,
        ACT_SKIP  = 2'd1,
        ACT_FLUSH = 2'd2
    } recov_act_e;

endpackage

// File: rtl/txr_bndq.sv
module txr_bndq #(
    parameter int QD = 4,
    parameter int PW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_i,
    input  logic [PW-1:0] push_val_i,
    input  logic          pop_i,
    input  logic          clr_i,
    output logic [PW-1:0] head_o,
    output logic          empty_o,
    output logic          full_o
);
    localparam int IW = (QD > 1) ? $clog2(QD) : 1;
    localparam int NW = $clog2(QD + 1);

    typedef struct packed {
        logic [QD-1:0][PW-1:0] ent;
        logic [IW-1:0]         rd;
        logic [IW-1:0]         wr;
        logic [NW-1:0]         num;
    } bq_st_t;

    bq_st_t st_d, st_q;
    logic   do_push, do_pop;

    function automatic logic [IW-1:0] idx_nxt(input logic [IW-1:0] i);
        return (i == IW'(QD - 1)) ? '0 : i + 1'b1;
    endfunction

    always_comb begin
        st_d    = st_q;
        do_pop  = pop_i && (st_q.num != '0);
        do_push = push_i && ((st_q.num != NW'(QD)) || do_pop);
        if (clr_i) begin
            st_d = '0;
        end else begin
            if (do_push) begin
                st_d.ent[st_q.wr] = push_val_i;
                st_d.wr           = idx_nxt(st_q.wr);
            end
            if (do_pop) begin
                st_d.rd = idx_nxt(st_q.rd);
            end
            st_d.num = st_q.num + NW'(do_push) - NW'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign head_o  = st_q.ent[st_q.rd];
    assign empty_o = (st_q.num == '0);
    assign full_o  = (st_q.num == NW'(QD));

    // R3
    bndq_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i && !clr_i) |-> (st_q.num != NW'(QD)));

    // R3
    bndq_count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.num <= NW'(QD));

endmodule

// File: rtl/txr_recov.sv
module txr_recov
    import txr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       abort_i,
    input  logic       stat_rd_i,
    input  logic       q_empty_i,
    output recov_act_e act_o,
    output logic       suspend_o,
    output logic       susp_nxt_o
);
    typedef struct packed {
        logic pend;
    } rc_st_t;

    rc_st_t st_d, st_q;

    always_comb begin
        st_d  = st_q;
        act_o = ACT_NONE;
        if (stat_rd_i && st_q.pend) begin
            st_d.pend = 1'b0;
            act_o     = q_empty_i ? ACT_FLUSH : ACT_SKIP;
        end else if (abort_i && !st_q.pend) begin
            st_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign suspend_o  = st_q.pend;
    assign susp_nxt_o = st_d.pend;

    // R4
    hold_needs_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.pend) |-> $past(abort_i));

    // R4
    hold_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.pend) |-> $past(stat_rd_i));

    // R8
    idle_read_no_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd_i && !st_q.pend) |-> (act_o == ACT_NONE));

endmodule

// File: rtl/txr_ptr.sv
module txr_ptr
    import txr_pkg::*;
#(
    parameter int AW     = 4,
    parameter int CW     = 4,
    parameter int WM_RST = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en_i,
    input  logic          wr_eof_i,
    input  logic          rd_en_i,
    input  logic          stat_rd_i,
    input  logic [AW:0]   cfg_wm_i,
    input  recov_act_e    act_i,
    input  logic          suspend_i,
    input  logic          susp_nxt_i,
    input  logic [AW:0]   q_head_i,
    input  logic          q_empty_i,
    input  logic          q_full_i,
    output logic          q_push_o,
    output logic [AW:0]   q_push_val_o,
    output logic          q_pop_o,
    output logic          q_clr_o,
    output logic [AW:0]   wr_ptr_o,
    output logic [AW:0]   rd_ptr_o,
    output logic [CW-1:0] frame_cnt_o,
    output logic          data_req_o
);
    localparam int PW    = AW + 1;
    localparam int DEPTH = 1 << AW;
    localparam logic DREQ_RST = (DEPTH >= WM_RST);

    typedef struct packed {
        logic [PW-1:0] wr;
        logic [PW-1:0] rd;
        logic [CW-1:0] cnt;
        logic [PW-1:0] wm;
        logic          dreq;
    } pt_st_t;

    pt_st_t        st_d, st_q;
    logic [PW-1:0] used_q, free_d, rd_nxt;
    logic          full_q, wr_ok, rd_ok, pop_rd, cnt_inc, cnt_dec;

    always_comb begin
        st_d    = st_q;
        used_q  = st_q.wr - st_q.rd;
        full_q  = (used_q == PW'(DEPTH));
        wr_ok   = wr_en_i && !full_q && !(wr_eof_i && q_full_i)
                  && (act_i != ACT_FLUSH);
        rd_ok   = rd_en_i && !suspend_i && (st_q.rd != st_q.wr);
        rd_nxt  = st_q.rd + 1'b1;
        pop_rd  = rd_ok && !q_empty_i && (rd_nxt == q_head_i);
        cnt_inc = wr_ok && wr_eof_i && (st_q.cnt != {CW{1'b1}});
        cnt_dec = stat_rd_i && (st_q.cnt != '0);

        if (act_i == ACT_FLUSH) begin
            st_d.wr  = '0;
            st_d.rd  = '0;
            st_d.cnt = '0;
            st_d.wm  = cfg_wm_i;
        end else begin
            if (act_i == ACT_SKIP) st_d.rd = q_head_i;
            else if (rd_ok)        st_d.rd = rd_nxt;
            if (wr_ok)             st_d.wr = st_q.wr + 1'b1;
            st_d.cnt = st_q.cnt + CW'(cnt_inc) - CW'(cnt_dec);
        end

        free_d    = PW'(DEPTH) - (st_d.wr - st_d.rd);
        st_d.dreq = !susp_nxt_i && (free_d >= st_d.wm);

        q_push_o     = wr_ok && wr_eof_i;
        q_push_val_o = st_q.wr + 1'b1;
        q_pop_o      = pop_rd || (act_i == ACT_SKIP);
        q_clr_o      = (act_i == ACT_FLUSH);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.wr   <= '0;
            st_q.rd   <= '0;
            st_q.cnt  <= '0;
            st_q.wm   <= PW'(WM_RST);
            st_q.dreq <= DREQ_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_ptr_o    = st_q.wr;
    assign rd_ptr_o    = st_q.rd;
    assign frame_cnt_o = st_q.cnt;
    assign data_req_o  = st_q.dreq;

    // R2
    occupancy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.wr - st_q.rd) <= PW'(DEPTH));

    // R5
    skip_keeps_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_i == ACT_SKIP && !wr_en_i) |=> (st_q.wr == $past(st_q.wr)));

    // R6
    flush_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_i == ACT_FLUSH) |=> (st_q.wr == '0 && st_q.rd == '0 && st_q.cnt == '0));

    // R9
    no_req_in_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        suspend_i |-> !st_q.dreq);

    // R4
    hold_freezes_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (suspend_i && act_i == ACT_NONE) |=> (st_q.rd == $past(st_q.rd)));

endmodule

// File: rtl/tx_abort_recovery.sv
module tx_abort_recovery
    import txr_pkg::*;
#(
    parameter int AW     = 4,
    parameter int QD     = 4,
    parameter int CW     = 4,
    parameter int WM_RST = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          wr_eof,
    input  logic          rd_en,
    input  logic          abort,
    input  logic          stat_rd,
    input  logic [AW:0]   cfg_wmark,
    output logic [AW:0]   wr_ptr,
    output logic [AW:0]   rd_ptr,
    output logic [CW-1:0] frame_cnt,
    output logic          tx_hold,
    output logic          data_req
);
    localparam int PW = AW + 1;

    recov_act_e    act;
    logic          susp_nxt;
    logic          q_push, q_pop, q_clr, q_empty, q_full;
    logic [PW-1:0] q_push_val, q_head;

    txr_recov i_recov (
        .clk        (clk),
        .rst_n      (rst_n),
        .abort_i    (abort),
        .stat_rd_i  (stat_rd),
        .q_empty_i  (q_empty),
        .act_o      (act),
        .suspend_o  (tx_hold),
        .susp_nxt_o (susp_nxt)
    );

    txr_bndq #(.QD(QD), .PW(PW)) i_bndq (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_i     (q_push),
        .push_val_i (q_push_val),
        .pop_i      (q_pop),
        .clr_i      (q_clr),
        .head_o     (q_head),
        .empty_o    (q_empty),
        .full_o     (q_full)
    );

    txr_ptr #(.AW(AW), .CW(CW), .WM_RST(WM_RST)) i_ptr (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en_i      (wr_en),
        .wr_eof_i     (wr_eof),
        .rd_en_i      (rd_en),
        .stat_rd_i    (stat_rd),
        .cfg_wm_i     (cfg_wmark),
        .act_i        (act),
        .suspend_i    (tx_hold),
        .susp_nxt_i   (susp_nxt),
        .q_head_i     (q_head),
        .q_empty_i    (q_empty),
        .q_full_i     (q_full),
        .q_push_o     (q_push),
        .q_push_val_o (q_push_val),
        .q_pop_o      (q_pop),
        .q_clr_o      (q_clr),
        .wr_ptr_o     (wr_ptr),
        .rd_ptr_o     (rd_ptr),
        .frame_cnt_o  (frame_cnt),
        .data_req_o   (data_req)
    );

endmodule

// File: tb/test_tx_abort_recovery.sv
module test_tx_abort_recovery;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, wr_eof = 1'b0, rd_en = 1'b0, abort = 1'b0, stat_rd = 1'b0;
    logic [4:0] cfg_wmark = 5'd8;
    logic [4:0] wr_ptr, rd_ptr;
    logic [3:0] frame_cnt;
    logic       tx_hold, data_req;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    // reference model state
    int m_wr = 0, m_rd = 0, m_cnt = 0, m_wm = 8, mqn = 0;
    int mq [4];
    bit m_pend = 1'b0;

    always #4 clk = ~clk;

    tx_abort_recovery i_tx_abort_recovery (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_eof(wr_eof), .rd_en(rd_en),
        .abort(abort), .stat_rd(stat_rd), .cfg_wmark(cfg_wmark), .wr_ptr(wr_ptr),
        .rd_ptr(rd_ptr), .frame_cnt(frame_cnt), .tx_hold(tx_hold), .data_req(data_req)
    );

    task automatic check(input string req, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
        end
    endtask

    function automatic bit exp_dreq();
        return !m_pend && ((16 - ((m_wr - m_rd) & 31)) >= m_wm);
    endfunction

    task automatic q_pop();
        for (int k = 0; k < 3; k++) mq[k] = mq[k+1];
        mqn--;
    endtask

    task automatic model_step(input bit w, input bit e, input bit r, input bit a, input bit s);
        int  used    = (m_wr - m_rd) & 31;
        int  cnt_old = m_cnt;
        int  qn_old  = mqn;
        bit  flush   = 1'b0;
        bit  wrote   = 1'b0;
        if (s && m_pend) begin
            m_pend = 1'b0;
            if (mqn == 0) begin
                flush = 1'b1; m_wr = 0; m_rd = 0; m_cnt = 0; m_wm = int'(cfg_wmark);
            end else begin
                m_rd = mq[0]; q_pop();
            end
        end else begin
            if (r && !m_pend && m_rd != m_wr) begin
                m_rd = (m_rd + 1) & 31;
                if (mqn > 0 && m_rd == mq[0]) q_pop();
            end
            if (a && !m_pend) m_pend = 1'b1;
        end
        if (!flush && w && used < 16 && !(e && qn_old == 4)) begin
            wrote = 1'b1;
            m_wr  = (m_wr + 1) & 31;
            if (e) begin mq[mqn] = m_wr; mqn++; end
        end
        if (!flush)
            m_cnt = cnt_old + ((wrote && e && cnt_old < 15) ? 1 : 0) - ((s && cnt_old > 0) ? 1 : 0);
    endtask

    task automatic compare_all();
        check("R2 wr_ptr", int'(wr_ptr), m_wr);
        check("R2 rd_ptr", int'(rd_ptr), m_rd);
        check("R7 frame_cnt", int'(frame_cnt), m_cnt);
        check("R4 tx_hold", int'(tx_hold), int'(m_pend));
        check("R9 data_req", int'(data_req), int'(exp_dreq()));
    endtask

    task automatic drive(input bit w, input bit e, input bit r, input bit a, input bit s);
        @(negedge clk);
        wr_en = w; wr_eof = e; rd_en = r; abort = a; stat_rd = s;
        @(posedge clk);
        #1;
        model_step(w, e, r, a, s);
        compare_all();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        // R1 reset state
        check("R1 wr_ptr", int'(wr_ptr), 0);
        check("R1 rd_ptr", int'(rd_ptr), 0);
        check("R1 frame_cnt", int'(frame_cnt), 0);
        check("R1 tx_hold", int'(tx_hold), 0);
        check("R1 data_req", int'(data_req), 1);

        // two complete frames, partial read, abort, skip
        drive(1,0,0,0,0); drive(1,0,0,0,0); drive(1,1,0,0,0);
        drive(1,0,0,0,0); drive(1,1,0,0,0);
        check("R3 frame_cnt", int'(frame_cnt), 2);
        drive(0,0,1,0,0);
        drive(0,0,0,1,0);
        check("R4 hold set", int'(tx_hold), 1);
        check("R4 data_req low", int'(data_req), 0);
        drive(0,0,1,0,0);
        check("R4 read ignored", int'(rd_ptr), 1);
        drive(0,0,0,1,0);  // R10 second abort
        drive(0,0,0,0,1);
        check("R5 rd skipped", int'(rd_ptr), 3);
        check("R5 wr kept", int'(wr_ptr), 5);
        check("R10 released by one read", int'(tx_hold), 0);
        check("R9 data_req back", int'(data_req), 1);

        // idle status reads
        drive(0,0,0,0,1);
        check("R8 rd unchanged", int'(rd_ptr), 3);
        check("R8 wr unchanged", int'(wr_ptr), 5);
        drive(0,0,0,0,1);
        check("R7 saturate", int'(frame_cnt), 0);

        // partial frame then abort -> flush
        drive(1,0,0,0,0); drive(1,0,0,0,0);
        drive(0,0,1,0,0); drive(0,0,1,0,0); drive(0,0,1,0,0);
        drive(0,0,0,1,0);
        cfg_wmark = 5'd12;
        drive(0,0,0,0,1);
        check("R6 wr zero", int'(wr_ptr), 0);
        check("R6 rd zero", int'(rd_ptr), 0);
        check("R6 data_req", int'(data_req), 1);
        for (int k = 0; k < 5; k++) drive(1,0,0,0,0);
        check("R6 new watermark", int'(data_req), 0);
        cfg_wmark = 5'd2;
        drive(0,0,0,0,0);
        check("R9 cfg deferred", int'(data_req), 0);
        for (int k = 0; k < 11; k++) drive(1,0,0,0,0);
        drive(1,0,0,0,0);
        check("R2 full write ignored", int'(wr_ptr), 16);

        // flush again, then fill the boundary queue
        drive(0,0,0,1,0);
        cfg_wmark = 5'd8;
        drive(0,0,0,0,1);
        for (int k = 0; k < 4; k++) drive(1,1,0,0,0);
        drive(1,1,0,0,0);
        check("R3 eof dropped wr", int'(wr_ptr), 4);
        check("R3 eof dropped cnt", int'(frame_cnt), 4);
        drive(1,0,0,0,0);
        check("R2 plain write", int'(wr_ptr), 5);

        // constrained random
        for (int i = 0; i < 4000; i++) begin
            bit w, e, r, a, s;
            w = ($urandom % 2) == 0;
            e = w && (($urandom % 4) == 0);
            r = ($urandom % 5) < 2;
            a = !m_pend && (($urandom % 60) == 0);
            s = ($urandom % 20) == 0;
            if (a) begin r = 1'b0; s = 1'b0; end
            if (($urandom % 100) == 0) cfg_wmark = 5'($urandom % 17);
            drive(w, e, r, a, s);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule